// File: doc/BRIEF.md
# Shared-Port Memory Access Sequencer

This block connects a small 32-bit pipelined core to one memory port that carries instruction fetches, loads and stores on a single bus. In normal running it presents the core's fetch address on every cycle and latches the returned word as the current opcode. When the core presents a load or store request, the block still completes the fetch of the following opcode in that cycle. It then takes the bus for a data phase at the request address. During the data phase it raises `pause_out` so the core holds its pipeline. After the data phase it returns to fetching.

The length of a data phase depends on the most significant address bit. Addresses with that bit clear are clocked memory, so every access there has a one-cycle data phase, two cycles in all with the fetch. A store to an address with the bit set gets a stretched data phase. The write strobe is high for two cycles, and one more cycle keeps address and data steady with the strobe low, so the access takes four cycles in all. Stores place their value on the byte lanes in big-endian order. Loads are shifted down and sign- or zero-extended before they are returned on `ld_data`, and `ld_valid` marks them for one cycle.

The core-side interface is plain control, not a handshake. A request is sampled only in a fetch cycle. The core applies back-pressure only through `ext_pause`, and while that input is high every register in the block holds. `ld_valid` has no ready: the core must take the load result in the cycle it is flagged. If `ext_pause` is high in that cycle, the flag and the data stay up until the next unpaused edge.

Top module: `memseq_unit`

## Requirements
- R1: A store whose address has bit 31 set has a data phase of three unpaused cycles. `mem_write` is high in the first two and low in the third, so the access takes four cycles counting the fetch that accepted it.
- R2: Any load, and any store whose address has bit 31 clear, has a data phase of exactly one unpaused cycle. `pause_out` falls in the next cycle.
- R3: In a fetch cycle `mem_addr` equals `fetch_addr`, and the edge that ends it latches `mem_rdata` into `opcode`. A request with `req_kind` 01 (load) or 10 (store) accepted in that cycle is followed by its data phase at `req_addr`. After the data phase `mem_addr` returns to `fetch_addr`.
- R4: During a store data phase `mem_byte_sel` is big-endian, with bit 3 the lane on data bits 31:24. For `req_size` 00 (byte) it is 1000, 0100, 0010 or 0001 for low address bits 00, 01, 10 or 11. For size 01 (halfword) it is 1100 when address bit 1 is 0 and 0011 when it is 1. For size 10 or 11 (word) it is 1111.
- R5: During a store data phase `mem_wdata` carries the low byte of `req_wdata` copied to all four lanes for byte stores, the low halfword copied to both halves for halfword stores, and the whole word for word stores.
- R6: `pause_out` is high in every data-phase cycle and low in every fetch cycle. Within a data phase `mem_addr`, `mem_wdata` and `mem_byte_sel` hold their values.
- R7: Outside a store data phase `mem_wdata` and `mem_byte_sel` are zero and `mem_write` is low. This includes load data phases.
- R8: At the end of a load data phase `ld_valid` goes high for one cycle. `ld_data` then holds the addressed byte (lane chosen as in R4) or halfword of `mem_rdata`, shifted to bit 0. It is sign-extended when `req_signed` is 1 and zero-extended when it is 0. A word load returns `mem_rdata` unchanged.
- R9: While `ext_pause` is high no state changes: `opcode`, the phase, its cycle count and the load outputs hold, and no new request is accepted.
- R10: When `nullify` is high at the edge that ends a fetch cycle, `opcode` becomes all zeros (a no-op) instead of `mem_rdata`.
- R11: While `rst_n` is low, `opcode`, `ld_data` and `ld_valid` are zero, `pause_out` and `mem_write` are low, and the block is in a fetch cycle.
- R12: A `req_kind` of 00 or 11 starts no data phase, and fetching continues the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pause | input | 1 | External stall; holds all state |
| nullify | input | 1 | Replace the opcode being fetched with a no-op |
| fetch_addr | input | 32 | Instruction address from the core |
| req_kind | input | 2 | 00 none, 01 load, 10 store, 11 none |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | 32 | Data access byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| opcode | output | 32 | Latched instruction word |
| ld_valid | output | 1 | Load result flag, one cycle |
| ld_data | output | 32 | Aligned and extended load result |
| pause_out | output | 1 | Stall request to the core during a data phase |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data, zero when no store is on the bus |
| mem_rdata | input | 32 | Memory read data |
| mem_byte_sel | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_write | output | 1 | Write strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a two-cycle write strobe and one hold cycle for the high region. These settings make the strobe-to-hold boundary and the one-cycle low-region phase visible at the ports. With them it sweeps every access size, every low address offset and both address regions for stores. For loads it also sweeps both signedness settings and two read patterns, one with the top bit set in every byte and one with it clear. It then pauses in the middle of a stretched store and during a fetch, nullifies a fetch, and offers reserved request codes.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
  localparam int LANES   = 4;
  localparam int DATA_W  = 8 * LANES;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  typedef struct packed {
    acc_kind_e         kind;
    acc_size_e         size;
    logic              sgn;
    logic [31:0]       addr;
    logic [DATA_W-1:0] wdata;
  } acc_req_t;
endpackage

// File: rtl/memseq_lanes.sv
module memseq_lanes
  import memseq_pkg::*;
(
  input  acc_size_e          size,
  input  logic [1:0]         offset,
  input  logic [DATA_W-1:0]  value,
  output logic [LANES-1:0]   sel,
  output logic [DATA_W-1:0]  spread
);
  // Lane i drives data bits 8i+7:8i; big-endian byte offset of lane i is LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] BYTE_OFS = 2'(LANES - 1 - i);
    localparam logic       LOW_HALF = (i < LANES / 2);
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          sel[i]         = (offset == BYTE_OFS);
          spread[8*i+:8] = value[7:0];
        end
        SZ_HALF: begin
          sel[i]         = (offset[1] == LOW_HALF);
          spread[8*i+:8] = value[8*(i%2)+:8];
        end
        default: begin
          sel[i]         = 1'b1;
          spread[8*i+:8] = value[8*i+:8];
        end
      endcase
    end
  end
endmodule

// File: rtl/memseq_align.sv
module memseq_align
  import memseq_pkg::*;
(
  input  acc_size_e          size,
  input  logic               sgn,
  input  logic [1:0]         offset,
  input  logic [DATA_W-1:0]  raw,
  output logic [DATA_W-1:0]  result
);
  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  always_comb begin
    unique case (offset)
      2'b00:   pick_b = raw[31:24];
      2'b01:   pick_b = raw[23:16];
      2'b10:   pick_b = raw[15:8];
      default: pick_b = raw[7:0];
    endcase
    pick_h = offset[1] ? raw[15:0] : raw[31:16];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){sgn & pick_b[7]}}, pick_b};
      SZ_HALF: result = {{(DATA_W-16){sgn & pick_h[15]}}, pick_h};
      default: result = raw;
    endcase
  end
endmodule

// File: rtl/memseq_ctrl.sv
module memseq_ctrl
  import memseq_pkg::*;
#(
  parameter int HI_STROBE = 2,
  parameter int HI_HOLD   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pause,
  input  logic accept,
  input  logic is_store,
  input  logic is_high,
  output logic in_data,
  output logic strobe,
  output logic last
);
  localparam int HI_LEN = HI_STROBE + HI_HOLD;
  localparam int CNT_W  = $clog2(HI_LEN + 1);
  localparam logic [CNT_W-1:0] STB_C  = CNT_W'(HI_STROBE);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HI_LEN - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stretched;

  assign stretched = is_store && is_high;
  assign in_data   = (phase_q == PH_DATA);
  assign last      = stretched ? (cnt_q == LAST_C) : 1'b1;
  assign strobe    = in_data && is_store && (stretched ? (cnt_q < STB_C) : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      cnt_q   <= '0;
    end else if (!ext_pause) begin
      unique case (phase_q)
        PH_FETCH: begin
          cnt_q <= '0;
          if (accept) phase_q <= PH_DATA;
        end
        default: begin
          if (last) begin
            phase_q <= PH_FETCH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/memseq_unit.sv
module memseq_unit
  import memseq_pkg::*;
#(
  parameter int HI_STROBE = 2,
  parameter int HI_HOLD   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_pause,
  input  logic        nullify,
  input  logic [31:0] fetch_addr,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] opcode,
  output logic        ld_valid,
  output logic [31:0] ld_data,
  output logic        pause_out,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [3:0]  mem_byte_sel,
  output logic        mem_write
);
  localparam int REGION_BIT = 31;

  acc_req_t          req_q;
  acc_kind_e         kind_in;
  logic              accept, in_data, strobe, last, is_store, is_load;
  logic [LANES-1:0]  lane_sel;
  logic [DATA_W-1:0] lane_data, aligned;

  assign kind_in  = acc_kind_e'(req_kind);
  assign accept   = !in_data && (kind_in == KIND_LOAD || kind_in == KIND_STORE);
  assign is_store = (req_q.kind == KIND_STORE);
  assign is_load  = (req_q.kind == KIND_LOAD);

  memseq_ctrl #(.HI_STROBE(HI_STROBE), .HI_HOLD(HI_HOLD)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pause (ext_pause),
    .accept    (accept),
    .is_store  (is_store),
    .is_high   (req_q.addr[REGION_BIT]),
    .in_data   (in_data),
    .strobe    (strobe),
    .last      (last)
  );

  memseq_lanes u_lanes (
    .size   (req_q.size),
    .offset (req_q.addr[1:0]),
    .value  (req_q.wdata),
    .sel    (lane_sel),
    .spread (lane_data)
  );

  memseq_align u_align (
    .size   (req_q.size),
    .sgn    (req_q.sgn),
    .offset (req_q.addr[1:0]),
    .raw    (mem_rdata),
    .result (aligned)
  );

  always_comb begin
    pause_out    = in_data;
    mem_addr     = in_data ? req_q.addr : fetch_addr;
    mem_write    = strobe;
    mem_byte_sel = (in_data && is_store) ? lane_sel : '0;
    mem_wdata    = (in_data && is_store) ? lane_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode   <= '0;
      req_q    <= '0;
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else if (!ext_pause) begin
      ld_valid <= 1'b0;
      if (!in_data) begin
        opcode <= nullify ? '0 : mem_rdata;
        if (accept) begin
          req_q.kind  <= kind_in;
          req_q.size  <= acc_size_e'(req_size);
          req_q.sgn   <= req_signed;
          req_q.addr  <= req_addr;
          req_q.wdata <= req_wdata;
        end
      end else if (last && is_load) begin
        ld_valid <= 1'b1;
        ld_data  <= aligned;
      end
    end
  end
endmodule

// File: rtl/memseq_checker.sv
module memseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_pause,
  input logic        pause_out,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_byte_sel,
  input logic        mem_write,
  input logic [31:0] opcode
);
  AST_HIGH_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_write) && mem_addr[31]) |=> mem_write); // R1

  AST_LOW_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_out && !mem_addr[31] && !ext_pause) |=> !pause_out); // R2

  AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> (pause_out && mem_byte_sel != 4'b0000)); // R4

  AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_out && $past(pause_out)) |->
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_byte_sel))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_out |-> (mem_wdata == 32'h0 && mem_byte_sel == 4'h0 && !mem_write)); // R7

  AST_FREEZE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pause |=> $stable(opcode)); // R9
endmodule

bind memseq_unit memseq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_pause    (ext_pause),
  .pause_out    (pause_out),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_byte_sel (mem_byte_sel),
  .mem_write    (mem_write),
  .opcode       (opcode)
);

// File: tb/memseq_unit_test.sv
module memseq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n, ext_pause, nullify, req_signed;
  logic [31:0] fetch_addr, req_addr, req_wdata, mem_rdata;
  logic [1:0]  req_kind, req_size;
  logic [31:0] opcode, ld_data, mem_addr, mem_wdata;
  logic        ld_valid, pause_out, mem_write;
  logic [3:0]  mem_byte_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memseq_unit uut (
    .clk(clk), .rst_n(rst_n), .ext_pause(ext_pause), .nullify(nullify),
    .fetch_addr(fetch_addr), .req_kind(req_kind), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .opcode(opcode), .ld_valid(ld_valid), .ld_data(ld_data),
    .pause_out(pause_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_byte_sel(mem_byte_sel), .mem_write(mem_write)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sel(int sz, logic [1:0] ofs);
    if (sz == 0) return 4'b1000 >> ofs;
    if (sz == 1) return ofs[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(int sz, logic [31:0] d);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] exp_ld(int sz, bit sg, logic [1:0] ofs, logic [31:0] r);
    logic [31:0] v;
    if (sz == 0) begin
      v = (r >> (8 * (3 - int'(ofs)))) & 32'hFF;
      if (sg && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      v = ofs[1] ? {16'h0, r[15:0]} : {16'h0, r[31:16]};
      if (sg && v[15]) v = v | 32'hFFFF_0000;
    end else v = r;
    return v;
  endfunction

  task automatic idle_inputs();
    req_kind = 2'b00; req_size = 2'b00; req_signed = 1'b0;
    req_addr = '0; req_wdata = '0; nullify = 1'b0; ext_pause = 1'b0;
  endtask

  task automatic do_store(bit hi, int sz, logic [1:0] ofs, logic [31:0] d, logic [31:0] f);
    logic [31:0] a;
    logic [31:0] opc;
    int n;
    a = {hi, 29'h0123_4560, ofs};
    opc = 32'hA000_0000 | f;
    n = hi ? 3 : 1;
    @(negedge clk);
    fetch_addr = f; mem_rdata = opc;
    req_kind = 2'b10; req_size = 2'(sz); req_addr = a; req_wdata = d;
    #1 chk("R3 fetch addr", mem_addr, f);
    chk("R6 fetch pause", 32'(pause_out), 0);
    @(negedge clk);
    req_kind = 2'b00; fetch_addr = f + 4; mem_rdata = 32'hDEAD_0000;
    #1 chk("R3 opcode latched", opcode, opc);
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R6 data pause", 32'(pause_out), 1);
      chk("R3 data addr", mem_addr, a);
      chk("R4 byte sel", 32'(mem_byte_sel), 32'(exp_sel(sz, ofs)));
      chk("R5 wdata", mem_wdata, exp_wd(sz, d));
      chk(hi ? "R1 strobe" : "R2 strobe", 32'(mem_write), (hi && k >= 2) ? 0 : 1);
    end
    @(negedge clk); #1;
    chk(hi ? "R1 phase end" : "R2 phase end", 32'(pause_out), 0);
    chk("R3 back to fetch", mem_addr, f + 4);
    chk("R7 quiet wdata", mem_wdata, 0);
    chk("R7 quiet sel", 32'(mem_byte_sel), 0);
    chk("R3 opcode held in phase", opcode, opc);
  endtask

  task automatic do_load(bit hi, int sz, bit sg, logic [1:0] ofs, logic [31:0] r);
    logic [31:0] a;
    a = {hi, 29'h0765_4320, ofs};
    @(negedge clk);
    fetch_addr = 32'h0000_0200; mem_rdata = 32'h1111_2222;
    req_kind = 2'b01; req_size = 2'(sz); req_signed = sg; req_addr = a;
    @(negedge clk);
    req_kind = 2'b00; mem_rdata = r;
    #1 chk("R3 load addr", mem_addr, a);
    chk("R7 load sel", 32'(mem_byte_sel), 0);
    chk("R7 load write", 32'(mem_write), 0);
    chk("R8 no early valid", 32'(ld_valid), 0);
    @(negedge clk); #1;
    chk("R2 load single", 32'(pause_out), 0);
    chk("R8 valid", 32'(ld_valid), 1);
    chk("R8 data", ld_data, exp_ld(sz, sg, ofs, r));
    @(negedge clk); #1;
    chk("R8 valid pulse", 32'(ld_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0; fetch_addr = 32'h100; mem_rdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 opcode", opcode, 0);
    chk("R11 ld_valid", 32'(ld_valid), 0);
    chk("R11 ld_data", ld_data, 0);
    chk("R11 pause", 32'(pause_out), 0);
    chk("R11 write", 32'(mem_write), 0);
    chk("R11 fetch addr", mem_addr, 32'h100);
    @(negedge clk); rst_n = 1'b1;

    for (int hi = 0; hi < 2; hi++)
      for (int sz = 0; sz < 4; sz++)
        for (int o = 0; o < 4; o++)
          do_store(hi[0], sz, 2'(o), 32'h8765_43A1 ^ (32'(o) << 4), 32'h1000 + 32'(o * 8));

    for (int hi = 0; hi < 2; hi++)
      for (int sz = 0; sz < 3; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int o = 0; o < 4; o++) begin
            do_load(hi[0], sz, sg[0], 2'(o), 32'h89AB_CDEF);
            do_load(hi[0], sz, sg[0], 2'(o), 32'h1234_5670);
          end

    // R10: nullify replaces the fetched word
    @(negedge clk); fetch_addr = 32'h300; mem_rdata = 32'hFFFF_FFFF; nullify = 1'b1;
    @(negedge clk); nullify = 1'b0; mem_rdata = 32'h0000_1234;
    #1 chk("R10 nullified", opcode, 0);
    @(negedge clk); #1 chk("R10 normal after", opcode, 32'h0000_1234);

    // R12: reserved and none kinds start nothing
    for (int kd = 0; kd < 4; kd += 3) begin
      @(negedge clk); req_kind = 2'(kd); req_addr = 32'h8000_0040; fetch_addr = 32'h400;
      @(negedge clk); req_kind = 2'b00; #1;
      chk("R12 no phase", 32'(pause_out), 0);
      chk("R12 fetch addr", mem_addr, 32'h400);
    end

    // R9: pause during fetch blocks capture and acceptance
    @(negedge clk); mem_rdata = 32'h5555_0000;
    @(negedge clk); ext_pause = 1'b1; req_kind = 2'b10; req_addr = 32'h8000_0010;
    mem_rdata = 32'h6666_0000;
    @(negedge clk); #1;
    chk("R9 opcode frozen", opcode, 32'h5555_0000);
    chk("R9 no accept", 32'(pause_out), 0);
    req_kind = 2'b00;

    // R9: pause inside a stretched store holds the count
    @(negedge clk); ext_pause = 1'b0; req_kind = 2'b10; req_size = 2'b10;
    req_addr = 32'h8000_0020; req_wdata = 32'hCAFE_F00D; fetch_addr = 32'h500;
    @(negedge clk); req_kind = 2'b00; ext_pause = 1'b1;
    #1 chk("R9 strobe first", 32'(mem_write), 1);
    repeat (2) begin
      @(negedge clk); #1;
      chk("R9 held strobe", 32'(mem_write), 1);
      chk("R9 held pause", 32'(pause_out), 1);
    end
    ext_pause = 1'b0;
    @(negedge clk); #1 chk("R1 second strobe", 32'(mem_write), 1);
    @(negedge clk); #1 chk("R1 hold cycle", 32'(mem_write), 0);
    chk("R1 hold pause", 32'(pause_out), 1);
    @(negedge clk); #1 chk("R1 end", 32'(pause_out), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule